// File: doc/BRIEF.md
# Load Overlap Hazard and Forwarding Detector

This block decides, for a load about to enter the issue queue, whether an older store in the load/store queue can supply the load's full value, or whether the load must wait. The caller presents the load's address and size together with every store older than the load. Each store has a valid bit, an address and a size, and queue slot 0 holds the oldest store. The block compares the load with every slot in parallel. The youngest valid store that touches any of the load's bytes decides the result.

Full forwarding is granted when that store starts at exactly the load's address and writes at least as many bytes. Any other touching store sets the hold output. Such a store either starts at the same address but is narrower, or starts elsewhere inside the region covered by the wider of the two accesses. The load then stays out of the ready queue until the store commits and its slot goes invalid, and afterwards it reads the cache. All accesses are 1, 2, 4 or 8 bytes wide and naturally aligned. Two accesses therefore overlap exactly when their addresses match after the bits below the larger size are cleared.

The decision is registered. Each cycle's inputs produce the outputs one clock later, and the result is recomputed from scratch every cycle.

Top module: `lsq_ovl_detect`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, hold_o, fwd_hit_o and fwd_idx_o are all zero.
- R2: The outputs show the decision for the inputs sampled at the previous rising edge. When ld_valid_i was low, hold_o and fwd_hit_o are both low whatever the stores are.
- R3: When the deciding store's address equals the load address and its size code is greater than or equal to the load's, fwd_hit_o is 1, hold_o is 0 and fwd_idx_o is that store's slot number. Size codes are 0=1, 1=2, 2=4 and 3=8 bytes.
- R4: When the deciding store has the load's address but a smaller size code (for example a 4-byte store and an 8-byte load), hold_o is 1 and fwd_hit_o is 0.
- R5: A store at a different address is treated as overlapping when the two addresses agree after clearing the bits below the larger of the two sizes. In that case hold_o is 1 and fwd_hit_o is 0. Example: an 8-byte store at 0x38 and a 4-byte load at 0x3C overlap.
- R6: When no valid store overlaps a valid load, hold_o and fwd_hit_o are both 0.
- R7: When several valid stores overlap the load, only the one in the highest-numbered slot (the youngest) decides between forwarding and holding. Older overlapping stores have no effect on the outputs.
- R8: A slot whose valid bit is 0 never causes a hold or a forward, whatever its address and size.
- R9: A hold caused by a store is released one cycle after that store's valid bit drops, provided no other store conflicts.
- R10: fwd_idx_o is zero whenever fwd_hit_o is 0. hold_o and fwd_hit_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 1 | A load is being considered this cycle |
| ld_addr_i | input | ADDR_W (32) | Byte address of the load |
| ld_size_i | input | 2 | Load size code: 0=1, 1=2, 2=4, 3=8 bytes |
| st_valid_i | input | DEPTH (8) | Per-slot valid bits of the older stores; slot 0 is oldest |
| st_addr_i | input | DEPTH*ADDR_W (256) | Store addresses; slot i at bits [i*ADDR_W +: ADDR_W] |
| st_size_i | input | DEPTH*2 (16) | Store size codes; slot i at bits [i*2 +: 2] |
| fwd_hit_o | output | 1 | The load takes its full value from the store in fwd_idx_o |
| fwd_idx_o | output | IDX_W (3) | Slot of the forwarding store |
| hold_o | output | 1 | The load must wait for a partially overlapping store to leave |

## Verification
Forwarding and holding can both be triggered in the same cycle when one store could fully forward while another store only partly overlaps. The bench provokes this by filling a low slot with a forwardable store and a higher slot with a conflicting one, and then the reverse arrangement. It expects the younger slot's verdict each time. It also ends a hold and starts a forward from a different slot in consecutive cycles, and checks that the release and the new forward index appear exactly one cycle after the inputs change. The expected results come from a byte-range intersection model, not from the masking rule the design uses.

// File: rtl/lsq_ovl_pkg.sv
package lsq_ovl_pkg;

    // Access width codes: number of bytes is 1 << code.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } acc_size_e;

    // Verdict of one store slot against the load.
    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_FWD  = 2'd1,
        CLS_HOLD = 2'd2
    } ovl_cls_e;

endpackage

// File: rtl/lsq_ovl_cmp.sv
module lsq_ovl_cmp
    import lsq_ovl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] ld_addr,
    input  acc_size_e         ld_size,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  acc_size_e         st_size,
    output ovl_cls_e          cls
);

    logic [1:0]        wide_code;
    logic [ADDR_W-1:0] keep_mask;
    logic              overlap;
    logic              same_start;
    logic              covers;

    always_comb begin
        // The wider access sets the alignment region compared.
        wide_code  = (st_size > ld_size) ? st_size : ld_size;
        keep_mask  = ~((ADDR_W'(1) << wide_code) - ADDR_W'(1));
        overlap    = (((st_addr ^ ld_addr) & keep_mask) == '0);
        same_start = (st_addr == ld_addr);
        covers     = (st_size >= ld_size);

        if (!st_valid || !overlap) begin
            cls = CLS_NONE;
        end else if (same_start && covers) begin
            cls = CLS_FWD;
        end else begin
            cls = CLS_HOLD;
        end
    end

endmodule

// File: rtl/lsq_ovl_pick.sv
module lsq_ovl_pick
    import lsq_ovl_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  ovl_cls_e [DEPTH-1:0] cls,
    output logic                 fwd,
    output logic                 hold,
    output logic [IDX_W-1:0]     idx
);

    // Later slots are younger: scanning upward, the last conflict wins,
    // which equals stopping at the first conflict seen from the youngest.
    always_comb begin
        fwd  = 1'b0;
        hold = 1'b0;
        idx  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cls[i] == CLS_FWD) begin
                fwd  = 1'b1;
                hold = 1'b0;
                idx  = IDX_W'(i);
            end else if (cls[i] == CLS_HOLD) begin
                fwd  = 1'b0;
                hold = 1'b1;
                idx  = '0;
            end
        end
    end

endmodule

// File: rtl/lsq_ovl_detect.sv
module lsq_ovl_detect
    import lsq_ovl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    ld_valid_i,
    input  logic [ADDR_W-1:0]       ld_addr_i,
    input  logic [1:0]              ld_size_i,
    input  logic [DEPTH-1:0]        st_valid_i,
    input  logic [DEPTH*ADDR_W-1:0] st_addr_i,
    input  logic [DEPTH*2-1:0]      st_size_i,
    output logic                    fwd_hit_o,
    output logic [IDX_W-1:0]        fwd_idx_o,
    output logic                    hold_o
);

    typedef struct packed {
        logic             hold;
        logic             fwd_hit;
        logic [IDX_W-1:0] fwd_idx;
    } verdict_t;

    ovl_cls_e [DEPTH-1:0] slot_cls;
    logic                 pick_fwd;
    logic                 pick_hold;
    logic [IDX_W-1:0]     pick_idx;
    verdict_t             verdict_d;
    verdict_t             verdict_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        lsq_ovl_cmp #(
            .ADDR_W (ADDR_W)
        ) u_cmp (
            .ld_addr  (ld_addr_i),
            .ld_size  (acc_size_e'(ld_size_i)),
            .st_valid (st_valid_i[g]),
            .st_addr  (st_addr_i[g*ADDR_W +: ADDR_W]),
            .st_size  (acc_size_e'(st_size_i[g*2 +: 2])),
            .cls      (slot_cls[g])
        );
    end

    lsq_ovl_pick #(
        .DEPTH (DEPTH)
    ) u_pick (
        .cls  (slot_cls),
        .fwd  (pick_fwd),
        .hold (pick_hold),
        .idx  (pick_idx)
    );

    always_comb begin
        verdict_d = '0;
        if (ld_valid_i) begin
            verdict_d.hold    = pick_hold;
            verdict_d.fwd_hit = pick_fwd;
            verdict_d.fwd_idx = pick_fwd ? pick_idx : '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            verdict_q <= '0;
        end else begin
            verdict_q <= verdict_d;
        end
    end

    assign hold_o    = verdict_q.hold;
    assign fwd_hit_o = verdict_q.fwd_hit;
    assign fwd_idx_o = verdict_q.fwd_idx;

endmodule

// File: rtl/lsq_ovl_chk.sv
module lsq_ovl_chk #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    ld_valid_i,
    input logic [ADDR_W-1:0]       ld_addr_i,
    input logic [1:0]              ld_size_i,
    input logic [DEPTH-1:0]        st_valid_i,
    input logic [DEPTH*ADDR_W-1:0] st_addr_i,
    input logic [DEPTH*2-1:0]      st_size_i,
    input logic                    fwd_hit_o,
    input logic [IDX_W-1:0]        fwd_idx_o,
    input logic                    hold_o
);

    logic             ld_v_q;
    logic [DEPTH-1:0] st_v_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ld_v_q <= 1'b0;
            st_v_q <= '0;
        end else begin
            ld_v_q <= ld_valid_i;
            st_v_q <= st_valid_i;
        end
    end

    // R10
    excl_verdict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(hold_o && fwd_hit_o));

    // R10
    idx_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fwd_hit_o |-> (fwd_idx_o == '0));

    // R2
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ld_v_q |-> (!hold_o && !fwd_hit_o));

    // R8
    fwd_src_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fwd_hit_o |-> st_v_q[fwd_idx_o]);

    // R9
    hold_needs_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_o |-> (st_v_q != '0));

endmodule

bind lsq_ovl_detect lsq_ovl_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/lsq_ovl_detect_bench.sv
module lsq_ovl_detect_bench;

    localparam int ADDR_W = 32;
    localparam int DEPTH  = 8;
    localparam int IDX_W  = $clog2(DEPTH);

    logic                    clk_i = 1'b0;
    logic                    rst_ni = 1'b0;
    logic                    ld_valid_i = 1'b0;
    logic [ADDR_W-1:0]       ld_addr_i = '0;
    logic [1:0]              ld_size_i = '0;
    logic [DEPTH-1:0]        st_valid_i = '0;
    logic [DEPTH*ADDR_W-1:0] st_addr_i = '0;
    logic [DEPTH*2-1:0]      st_size_i = '0;
    logic                    fwd_hit_o;
    logic [IDX_W-1:0]        fwd_idx_o;
    logic                    hold_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        string      tag;
        logic       hold;
        logic       fwd;
        logic [IDX_W-1:0] idx;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk_i = ~clk_i;

    lsq_ovl_detect #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_lsq_ovl_detect (.*);

    // Byte-range intersection model, youngest slot first.
    function automatic exp_t model(string tag);
        exp_t e;
        logic done;
        longint lb, sb, la, sa;
        e.tag = tag; e.hold = 0; e.fwd = 0; e.idx = '0;
        done = 0;
        if (ld_valid_i) begin
            la = longint'(ld_addr_i);
            lb = longint'(1) << ld_size_i;
            for (int i = DEPTH - 1; i >= 0; i--) begin
                if (!done && st_valid_i[i]) begin
                    sa = longint'(st_addr_i[i*ADDR_W +: ADDR_W]);
                    sb = longint'(1) << st_size_i[i*2 +: 2];
                    if (sa < la + lb && la < sa + sb) begin
                        done = 1;
                        if (sa == la && sb >= lb) begin
                            e.fwd = 1;
                            e.idx = IDX_W'(i);
                        end else begin
                            e.hold = 1;
                        end
                    end
                end
            end
        end
        return e;
    endfunction

    task automatic set_entry(int i, logic v, logic [ADDR_W-1:0] a, logic [1:0] s);
        st_valid_i[i]                = v;
        st_addr_i[i*ADDR_W +: ADDR_W] = a;
        st_size_i[i*2 +: 2]          = s;
    endtask

    task automatic set_load(logic v, logic [ADDR_W-1:0] a, logic [1:0] s);
        ld_valid_i = v;
        ld_addr_i  = a;
        ld_size_i  = s;
    endtask

    // Driver: inputs were set during the low phase; push the expectation,
    // let one rising edge pass, return in the next low phase.
    task automatic step(string tag);
        sb_q.push_back(model(tag));
        @(posedge clk_i);
        @(negedge clk_i);
    endtask

    // Monitor: outputs settle just after the edge that captured the inputs.
    always @(posedge clk_i) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (hold_o !== e.hold || fwd_hit_o !== e.fwd || fwd_idx_o !== e.idx) begin
                errors++;
                $display("FAIL %s: hold=%0b fwd=%0b idx=%0d expected hold=%0b fwd=%0b idx=%0d",
                         e.tag, hold_o, fwd_hit_o, fwd_idx_o, e.hold, e.fwd, e.idx);
            end
        end
    end

    task automatic clear_all();
        st_valid_i = '0;
        st_addr_i  = '0;
        st_size_i  = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        // R1: reset values while reset is held
        checks++;
        if (hold_o !== 1'b0 || fwd_hit_o !== 1'b0 || fwd_idx_o !== '0) begin
            errors++;
            $display("FAIL R1 reset: hold=%0b fwd=%0b idx=%0d expected 0 0 0",
                     hold_o, fwd_hit_o, fwd_idx_o);
        end
        rst_ni = 1'b1;
        @(negedge clk_i);
        checks++;
        if (hold_o !== 1'b0 || fwd_hit_o !== 1'b0 || fwd_idx_o !== '0) begin
            errors++;
            $display("FAIL R1 after reset: hold=%0b fwd=%0b idx=%0d expected 0 0 0",
                     hold_o, fwd_hit_o, fwd_idx_o);
        end

        // R2: no load -> quiet, even with an exact matching store
        set_entry(3, 1, 32'h100, 2'd3);
        set_load(0, 32'h100, 2'd3);
        step("R2 load invalid");

        // R3: exact match, equal and larger store
        set_load(1, 32'h100, 2'd3);
        step("R3 exact 8B to 8B slot3");
        set_load(1, 32'h100, 2'd2);
        step("R3 8B store to 4B load");

        // R4: same start, store narrower
        clear_all();
        set_entry(2, 1, 32'h200, 2'd2);
        set_load(1, 32'h200, 2'd3);
        step("R4 4B store 8B load");

        // R5: 8B store at 0x38, 4B load at 0x3C
        clear_all();
        set_entry(5, 1, 32'h38, 2'd3);
        set_load(1, 32'h3C, 2'd2);
        step("R5 8B@38 vs 4B@3C");
        // R5: narrow store inside wide load
        clear_all();
        set_entry(0, 1, 32'h3B, 2'd0);
        set_load(1, 32'h38, 2'd3);
        step("R5 1B@3B vs 8B@38");

        // R6: adjacent but disjoint
        clear_all();
        set_entry(4, 1, 32'h40, 2'd2);
        set_load(1, 32'h44, 2'd2);
        step("R6 adjacent words");

        // R7: older forwardable, younger partial -> hold
        clear_all();
        set_entry(1, 1, 32'h80, 2'd3);
        set_entry(5, 1, 32'h84, 2'd2);
        set_load(1, 32'h80, 2'd3);
        step("R7 younger partial wins");
        // R7: older partial, younger forwardable -> forward from slot 6
        clear_all();
        set_entry(1, 1, 32'h84, 2'd2);
        set_entry(6, 1, 32'h80, 2'd3);
        step("R7 younger forward wins");
        // R7: two forwardable -> youngest index
        set_entry(2, 1, 32'h80, 2'd3);
        step("R7 youngest of two forwards");

        // R8: invalid overlapping slot ignored
        clear_all();
        set_entry(7, 0, 32'h80, 2'd3);
        step("R8 invalid slot");

        // R9: hold, release, then forward from another slot next cycle
        clear_all();
        set_entry(4, 1, 32'h300, 2'd1);
        set_entry(2, 1, 32'h300, 2'd3);
        set_load(1, 32'h300, 2'd2);
        step("R9 hold while slot4 valid");
        set_entry(4, 0, 32'h300, 2'd1);
        step("R9 release, forward slot2");
        set_entry(2, 0, 32'h300, 2'd3);
        step("R9 empty queue no hold");

        // R5 / R6 / R3 sweep: 4B store at 0x204 against aligned loads
        clear_all();
        set_entry(3, 1, 32'h204, 2'd2);
        for (int sz = 0; sz < 4; sz++) begin
            for (int off = 0; off < 16; off += (1 << sz)) begin
                set_load(1, 32'h200 + off, 2'(sz));
                step($sformatf("R5 sweep size%0d off%0d", sz, off));
            end
        end

        // R10: many slots, last load idle
        set_load(0, 32'h204, 2'd2);
        step("R10 idle index zero");

        repeat (2) @(negedge clk_i);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule